// File: doc/BRIEF.md
# Gated Continuous Queue Scanner

This block steps through a table of conversion command words for as long as an external gate input stays high. The point is to keep fresh samples coming in. Each command word names an analog channel. For each word, the block sends a one-cycle start request with that channel to an external conversion engine. It then waits for the engine's done pulse and passes the returned data out with the table index it belongs to.

The gate is read only at the moment a conversion finishes. A conversion that is running when the gate drops always runs to the end and counts as valid. When the queue reaches its end with the gate still open, the block raises a complete flag and wraps to the first word. If the queue ends again before software clears that flag, the block raises an overrun flag instead. If the gate is found closed part-way through the queue, the block stops, raises an incomplete flag and keeps a pointer to the last word converted. When the gate opens again, the scan always restarts at the first word. All three flags are cleared by writing one. Dropping the enable input aborts the scan at once.

Top module: `gated_scan_ctrl`

## Requirements
- R1: After reset, all three flags read 0, `last_ptr` is 0 and neither `conv_start` nor `sample_we` is asserted.
- R2: With `en` high and the block waiting, a high `gate` issues a one-cycle `conv_start` for table entry 0. After that, entries are converted in ascending index order, and `conv_chan` carries bits [CH_W-1:0] of the entry.
- R3: The gate level is examined only in the cycle `conv_done` arrives. A low pulse that ends before that cycle has no effect. A conversion in progress when the gate falls completes and is counted.
- R4: The queue ends after the entry at index DEPTH-1, or after an entry whose successor has a channel field of all ones (the end marker). Reaching that end with the gate open sets `flag_cf` (clear-bit 0) when it is clear, and the scan continues at entry 0.
- R5: Reaching the end of the queue while `flag_cf` is already set sets `flag_tor` (clear-bit 1), and the scan wraps to entry 0 again.
- R6: A low gate seen at a conversion that does not end the queue stops the scan and sets `flag_pf` (clear-bit 2). A low gate seen at the conversion that ends the queue stops the scan without setting `flag_pf`. In both cases `last_ptr` holds the index of the last finished conversion.
- R7: After the scan stops on a closed gate, the next high gate restarts it at entry 0.
- R8: The pause bit (bit CH_W of an entry) has no effect. It neither stops the scan nor sets `flag_pf`.
- R9: Writing one to a bit of `flag_clr` clears that flag. Zero bits leave their flags unchanged, and a set in the same cycle wins over a clear.
- R10: Low `en` returns the block to idle within one cycle. No `conv_start` is issued while `en` is low, and the flags are kept.
- R11: Each accepted `conv_done` gives one `sample_we` pulse, with `sample_idx` equal to the entry index and `sample_data` equal to `conv_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Scan enable; low aborts to idle |
| gate | input | 1 | Gate level, high = open |
| tbl_we | input | 1 | Command table write strobe |
| tbl_addr | input | IDX_W | Command table write index |
| tbl_wdata | input | CH_W+1 | Command word: {pause, channel} |
| flag_clr | input | 3 | Write-one-to-clear: bit0 CF, bit1 TOR, bit2 PF |
| conv_start | output | 1 | Start request to the conversion engine |
| conv_chan | output | CH_W | Channel of the requested conversion |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | DATA_W | Conversion result |
| sample_we | output | 1 | Result valid strobe |
| sample_idx | output | IDX_W | Table index of the result |
| sample_data | output | DATA_W | Result value |
| flag_cf | output | 1 | Queue completed |
| flag_tor | output | 1 | Queue completed again while CF set |
| flag_pf | output | 1 | Queue stopped incomplete |
| last_ptr | output | IDX_W | Index of last finished conversion |

## Verification
Several rules are checked by the assertions on every cycle. Start requests are single-cycle and stop within a cycle of `en` falling. An incomplete flag only ever rises after a done pulse seen with the gate low. The overrun flag only rises while the complete flag is set. A stop always returns the index to zero. The pointer moves only with a result strobe. The bench scenarios are the only place to show the channel order, where the queue ends (at the marker and at the table end), wrapping, restart at entry 0 after closure, a gate glitch being missed, pause bits being ignored, and the clear-bit mapping.

// File: rtl/gscan_pkg.sv
package gscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_BUSY  = 2'd3
  } scan_st_t;

  localparam int FLG_CF  = 0;
  localparam int FLG_TOR = 1;
  localparam int FLG_PF  = 2;
  localparam int FLG_N   = 3;

  // queue ends after the last slot, or when the following entry is the end marker
  function automatic logic queue_ends(int unsigned idx, int unsigned depth, logic next_is_marker);
    return (idx == depth - 1) || next_is_marker;
  endfunction

endpackage

// File: rtl/gscan_table.sv
module gscan_table #(
  parameter int DEPTH = 16,
  parameter int CCW_W = 7,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CCW_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_cur,
  output logic [CCW_W-1:0] rdata_cur,
  input  logic [IDX_W-1:0] raddr_nxt,
  output logic [CCW_W-1:0] rdata_nxt
);

  logic [CCW_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata_cur = words[raddr_cur];
  assign rdata_nxt = words[raddr_nxt];

endmodule

// File: rtl/gscan_flags.sv
module gscan_flags
  import gscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             complete_ev,
  input  logic             incomplete_ev,
  input  logic [FLG_N-1:0] clr,
  output logic             cf,
  output logic             tor,
  output logic             pf
);

  logic set_cf, set_tor;

  assign set_cf  = complete_ev && !cf;
  assign set_tor = complete_ev &&  cf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cf  <= 1'b0;
      tor <= 1'b0;
      pf  <= 1'b0;
    end else begin
      cf  <= (cf  && !clr[FLG_CF])  || set_cf;
      tor <= (tor && !clr[FLG_TOR]) || set_tor;
      pf  <= (pf  && !clr[FLG_PF])  || incomplete_ev;
    end
  end

endmodule

// File: rtl/gscan_seq.sv
module gscan_seq
  import gscan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate,
  input  logic             conv_done,
  input  logic             next_is_marker,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] last_ptr,
  output logic             start_req,
  output logic             done_hit,
  output logic             complete_ev,
  output logic             stop_ev,
  output logic             incomplete_ev
);

  scan_st_t st;
  logic     at_end;

  assign at_end        = queue_ends(32'(cur_idx), DEPTH, next_is_marker);
  assign done_hit      = en && (st == ST_BUSY) && conv_done;
  assign complete_ev   = done_hit && at_end;
  assign stop_ev       = done_hit && !gate;
  assign incomplete_ev = stop_ev && !at_end;
  assign start_req     = en && (st == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_idx  <= '0;
      last_ptr <= '0;
    end else if (!en) begin
      st      <= ST_IDLE;
      cur_idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  st <= ST_WAIT;
        ST_WAIT:  if (gate) st <= ST_ISSUE;
        ST_ISSUE: st <= ST_BUSY;
        ST_BUSY: begin
          if (conv_done) begin
            last_ptr <= cur_idx;
            if (!gate) begin
              st      <= ST_WAIT;
              cur_idx <= '0;
            end else begin
              st      <= ST_ISSUE;
              cur_idx <= at_end ? '0 : cur_idx + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gated_scan_ctrl.sv
module gated_scan_ctrl
  import gscan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CH_W   = 6,
  parameter int DATA_W = 10,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CCW_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              gate,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [CCW_W-1:0]  tbl_wdata,
  input  logic [FLG_N-1:0]  flag_clr,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sample_we,
  output logic [IDX_W-1:0]  sample_idx,
  output logic [DATA_W-1:0] sample_data,
  output logic              flag_cf,
  output logic              flag_tor,
  output logic              flag_pf,
  output logic [IDX_W-1:0]  last_ptr
);

  logic [IDX_W-1:0] cur_idx, nxt_idx;
  logic [CCW_W-1:0] cur_word, nxt_word;
  logic             next_is_marker;
  logic             done_hit, complete_ev, stop_ev, incomplete_ev;

  assign nxt_idx        = cur_idx + 1'b1;
  assign next_is_marker = (nxt_word[CH_W-1:0] == {CH_W{1'b1}});

  gscan_table #(.DEPTH(DEPTH), .CCW_W(CCW_W), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .we        (tbl_we),
    .waddr     (tbl_addr),
    .wdata     (tbl_wdata),
    .raddr_cur (cur_idx),
    .rdata_cur (cur_word),
    .raddr_nxt (nxt_idx),
    .rdata_nxt (nxt_word)
  );

  gscan_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .gate           (gate),
    .conv_done      (conv_done),
    .next_is_marker (next_is_marker),
    .cur_idx        (cur_idx),
    .last_ptr       (last_ptr),
    .start_req      (conv_start),
    .done_hit       (done_hit),
    .complete_ev    (complete_ev),
    .stop_ev        (stop_ev),
    .incomplete_ev  (incomplete_ev)
  );

  gscan_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .complete_ev   (complete_ev),
    .incomplete_ev (incomplete_ev),
    .clr           (flag_clr),
    .cf            (flag_cf),
    .tor           (flag_tor),
    .pf            (flag_pf)
  );

  assign conv_chan   = cur_word[CH_W-1:0];
  assign sample_we   = done_hit;
  assign sample_idx  = cur_idx;
  assign sample_data = conv_data;

endmodule

// File: rtl/gscan_chk.sv
module gscan_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             gate,
  input logic             conv_start,
  input logic             conv_done,
  input logic             sample_we,
  input logic             flag_cf,
  input logic             flag_tor,
  input logic             flag_pf,
  input logic             stop_ev,
  input logic [IDX_W-1:0] cur_idx,
  input logic [IDX_W-1:0] last_ptr
);

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !conv_start);

  p_pf_after_closed_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_pf) |-> $past(conv_done && !gate));

  p_tor_needs_cf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_tor) |-> $past(flag_cf));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (cur_idx == '0));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_we |=> $stable(last_ptr));

  p_sample_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_we |-> conv_done);

endmodule

bind gated_scan_ctrl gscan_chk #(.IDX_W(IDX_W)) u_gscan_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .gate       (gate),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .sample_we  (sample_we),
  .flag_cf    (flag_cf),
  .flag_tor   (flag_tor),
  .flag_pf    (flag_pf),
  .stop_ev    (stop_ev),
  .cur_idx    (cur_idx),
  .last_ptr   (last_ptr)
);

// File: tb/test_gated_scan_ctrl.sv
module test_gated_scan_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int CH_W   = 6;
  localparam int DATA_W = 10;
  localparam int IDX_W  = 4;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, gate = 1'b0, tbl_we = 1'b0;
  logic [IDX_W-1:0] tbl_addr = '0;
  logic [CH_W:0] tbl_wdata = '0;
  logic [2:0] flag_clr = '0;
  logic conv_start, conv_done, sample_we, flag_cf, flag_tor, flag_pf;
  logic [CH_W-1:0] conv_chan;
  logic [DATA_W-1:0] conv_data, sample_data;
  logic [IDX_W-1:0] sample_idx, last_ptr;

  int n_tests = 0, n_fail = 0;
  int nlog = 0, ndone = 0, cnt = 0;
  int chan_log [64];
  logic busy = 1'b0;
  logic [CH_W-1:0] cur_chan = '0;
  int last_sidx = 0, last_sdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_scan_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W), .DATA_W(DATA_W)) i_gated_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .gate(gate),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .flag_clr(flag_clr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .sample_we(sample_we), .sample_idx(sample_idx), .sample_data(sample_data),
    .flag_cf(flag_cf), .flag_tor(flag_tor), .flag_pf(flag_pf), .last_ptr(last_ptr)
  );

  // conversion engine model: done LAT cycles after start, data = {chan, 4'b1010}
  assign conv_data = {cur_chan, 4'b1010};
  initial conv_done = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      nlog = 0; ndone = 0; busy = 1'b0; conv_done <= 1'b0; cnt = 0;
    end else begin
      if (sample_we) begin last_sidx = int'(sample_idx); last_sdata = int'(sample_data); end
      conv_done <= 1'b0;
      if (conv_start) begin
        busy = 1'b1; cnt = LAT; cur_chan <= conv_chan;
        if (nlog < 64) chan_log[nlog] = int'(conv_chan);
        nlog = nlog + 1;
      end else if (busy) begin
        if (cnt == 1) begin conv_done <= 1'b1; busy = 1'b0; ndone = ndone + 1; end
        cnt = cnt - 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; gate = 1'b0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(int a, int pause, int ch);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IDX_W'(a); tbl_wdata = {1'(pause), CH_W'(ch)};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // entries 0..3 = channels 5,9,2,14; entry 4 = end marker
  task automatic load_short(int pause);
    wr(0, pause, 5); wr(1, pause, 9); wr(2, pause, 2); wr(3, pause, 14); wr(4, 0, 63);
  endtask

  task automatic wait_log(string req, int k);
    int t = 0;
    while (nlog < k && t < 2000) begin @(posedge clk); t++; end
    if (t >= 2000) chk({req, " start timeout"}, nlog, k);
    @(negedge clk);
  endtask

  task automatic wait_done(string req, int k);
    int t = 0;
    while (ndone < k && t < 2000) begin @(posedge clk); t++; end
    if (t >= 2000) chk({req, " done timeout"}, ndone, k);
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cf", int'(flag_cf), 0);
    chk("R1 tor", int'(flag_tor), 0);
    chk("R1 pf", int'(flag_pf), 0);
    chk("R1 ptr", int'(last_ptr), 0);
    chk("R1 start", int'(conv_start), 0);
    chk("R1 sample_we", int'(sample_we), 0);
  endtask

  task automatic t_run_wrap();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_done("R4", 4);
    chk("R2 order0", chan_log[0], 5);
    chk("R2 order1", chan_log[1], 9);
    chk("R2 order2", chan_log[2], 2);
    chk("R2 order3", chan_log[3], 14);
    chk("R4 cf", int'(flag_cf), 1);
    chk("R5 tor clear", int'(flag_tor), 0);
    chk("R11 idx", last_sidx, 3);
    chk("R11 data", last_sdata, (14 << 4) | 10);
    wait_log("R4", 5);
    chk("R4 wrap", chan_log[4], 5);
    wait_done("R5", 8);
    chk("R5 tor", int'(flag_tor), 1);
    chk("R5 wrap", chan_log[8], 5);
  endtask

  task automatic t_close_mid();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_log("R6", 2);
    gate = 1'b0;
    wait_done("R6", 2);
    chk("R6 pf", int'(flag_pf), 1);
    chk("R6 cf", int'(flag_cf), 0);
    chk("R3 inflight ptr", int'(last_ptr), 1);
    repeat (10) @(negedge clk);
    chk("R6 stopped", nlog, 2);
    gate = 1'b1;
    wait_log("R7", 3);
    chk("R7 restart", chan_log[2], 5);
  endtask

  task automatic t_glitch();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_log("R3", 2);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    wait_done("R3", 4);
    chk("R3 glitch pf", int'(flag_pf), 0);
    chk("R3 glitch cf", int'(flag_cf), 1);
    chk("R3 glitch order", chan_log[2], 2);
  endtask

  task automatic t_pause();
    do_reset(); load_short(1);
    en = 1'b1; gate = 1'b1;
    wait_done("R8", 4);
    chk("R8 pf", int'(flag_pf), 0);
    chk("R8 cf", int'(flag_cf), 1);
    chk("R8 ran", chan_log[3], 14);
  endtask

  task automatic t_close_at_end_and_clear();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_log("R6", 4);
    gate = 1'b0;
    wait_done("R6", 4);
    chk("R6 end cf", int'(flag_cf), 1);
    chk("R6 end pf", int'(flag_pf), 0);
    chk("R6 end ptr", int'(last_ptr), 3);
    flag_clr = 3'b110;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R9 other bits", int'(flag_cf), 1);
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R9 cf clear", int'(flag_cf), 0);
  endtask

  task automatic t_pf_clear();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_log("R9", 1);
    gate = 1'b0;
    wait_done("R9", 1);
    chk("R9 pf set", int'(flag_pf), 1);
    flag_clr = 3'b100;
    @(negedge clk);
    flag_clr = 3'b000;
    chk("R9 pf clear", int'(flag_pf), 0);
  endtask

  task automatic t_full_table();
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr(i, 0, i + 1);
    en = 1'b1; gate = 1'b1;
    wait_done("R4", DEPTH);
    chk("R4 table end cf", int'(flag_cf), 1);
    chk("R4 last entry", chan_log[DEPTH-1], DEPTH);
    wait_log("R4", DEPTH + 1);
    chk("R4 table wrap", chan_log[DEPTH], 1);
  endtask

  task automatic t_abort();
    do_reset(); load_short(0);
    en = 1'b1; gate = 1'b1;
    wait_log("R10", 2);
    en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no start", nlog, 2);
    chk("R10 flags kept", int'({flag_cf, flag_tor, flag_pf}), 0);
    en = 1'b1;
    wait_log("R10", 3);
    chk("R10 restart", chan_log[2], 5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_run_wrap();
    t_close_mid();
    t_glitch();
    t_pause();
    t_close_at_end_and_clear();
    t_pf_clear();
    t_full_table();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule